// File: doc/BRIEF.md
# Single-Phase Fan Drive Duty Controller

This block controls a single-phase, full-wave fan motor from two digitized Hall polarity inputs. Every accepted Hall polarity change opens a new half-period. Near the rated speed the controller keeps both bridge enables off for a fixed idle wait. It then drives the coil that matches the current polarity for a selectable share of a programmed rated half-period. A tach output follows the polarity, with an open-collector sense: 1 means the pin is pulled low.

When the motor turns too slowly, the controller drives the coil for the whole half-period, and it always starts in this forced mode after reset. An over-temperature comparator with hysteresis works on a digital temperature code. While it is tripped, it masks both drive enables and the tach output. The rated half-period is given in clock ticks. The wait and window boundaries are derived from it by Q10 fixed-point products at the start of each half-period.

Top module: `fan_duty_ctrl`

## Requirements
- R1: The Hall inputs each pass through a two-stage synchronizer. A polarity change is accepted only when the synchronized pair is complementary (hallA=1,hallB=0 is phase A; hallA=0,hallB=1 is phase B) and differs from the current phase. A pair that reads 11 or 00 is ignored. An accepted change shows on the outputs at the third rising edge after the inputs settle.
- R2: In duty mode, both enables stay off while the half-period tick count (0 in the cycle after the change) is below wait = floor(rated*328/1024).
- R3: In duty mode, drive is on while the count is at least wait and below wait+dur, where dur = floor(rated*Q/1024). Q is 287 for {selHi,selLo}=00, 389 for 01, 492 for 10 and 594 for 11.
- R4: In phase A only driveA may be on, and tachLow is 0. In phase B only driveB may be on, and tachLow is 1. Outside the window both enables are off while tachLow keeps following the phase.
- R5: Forced mode is set at reset, and it is also set whenever count*13 > rated*20 (the half-period is longer than rated/0.65). In forced mode the enable of the current phase is on for the whole half-period.
- R6: On an accepted change, the mode for the new half-period becomes forced if the completed count met the R5 slow test, and duty mode otherwise.
- R7: An over-temperature flag sets when tempCode >= 170 and clears when tempCode <= 140, one cycle after the code is applied. While it is set, driveA, driveB and tachLow are all 0.
- R8: The half-period counter saturates at its maximum value and never wraps.
- R9: The wait and window boundaries are latched only on an accepted change. A change of ratedHalf or of the select inputs in mid-half-period has no effect until the next change.
- R10: After reset, the phase is A, forced mode is set and the flag is clear, so driveA=1, driveB=0 and tachLow=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hallA | input | 1 | Digitized Hall polarity, first sensor side |
| hallB | input | 1 | Digitized Hall polarity, second sensor side |
| selLo | input | 1 | Duty select, low bit |
| selHi | input | 1 | Duty select, high bit |
| tempCode | input | 8 | Die temperature code |
| ratedHalf | input | 16 | Rated half-period in clock ticks |
| driveA | output | 1 | Bridge enable for phase A current |
| driveB | output | 1 | Bridge enable for phase B current |
| tachLow | output | 1 | 1 = tach pin pulled low |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, two synchronizer stages and thresholds of 170/140. With ratedHalf set to 100, the wait and the four window widths land on whole tick counts (32, 28, 37, 48, 58), so the window lengths can be counted exactly at the ports. The 16-bit default keeps counter saturation within reach of a single 65,566-cycle Hall hold, which tells a saturating counter apart from a wrapping one by the mode the next half-period takes. Slow half-periods of 200 ticks cross the 154-tick forced threshold, and 100-tick half-periods return the block to duty mode.

// File: rtl/fan_pkg.sv
package fan_pkg;

  // Fixed-point fraction width of the percentage constants
  localparam int FRAC_W = 10;

  // Idle wait, about 32 % of the rated half-period
  localparam int WAIT_Q = 328;

  // Strobes and state from control to datapath and output stage
  typedef struct packed {
    logic restart;   // accepted Hall polarity change this cycle
    logic forced;    // full-interval drive mode
    logic phaseB;    // current phase, 1 = phase B
    logic overTemp;  // thermal mask
  } ctrlStb_t;

  // Status from datapath back to control
  typedef struct packed {
    logic overSlow;  // current half-period longer than the slow limit
    logic inWindow;  // count inside the drive window
  } dpStat_t;

  // Duty window constants in Q10, indexed by {selHi, selLo}
  function automatic int dutyQ(input logic [1:0] sel);
    case (sel)
      2'b00:   return 287;
      2'b01:   return 389;
      2'b10:   return 492;
      default: return 594;
    endcase
  endfunction

endpackage

// File: rtl/fan_ctrl.sv
module fan_ctrl
  import fan_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TEMP_W      = 8,
  parameter int TEMP_SET    = 170,
  parameter int TEMP_CLR    = 140
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hallA,
  input  logic              hallB,
  input  logic [TEMP_W-1:0] tempCode,
  input  dpStat_t           stat,
  output ctrlStb_t          stb
);

  localparam logic [TEMP_W-1:0] SET_LVL = TEMP_W'(TEMP_SET);
  localparam logic [TEMP_W-1:0] CLR_LVL = TEMP_W'(TEMP_CLR);

  logic [SYNC_STAGES-1:0] syncA;
  logic [SYNC_STAGES-1:0] syncB;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncA <= '0;
          syncB <= '0;
        end else begin
          syncA <= hallA;
          syncB <= hallB;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncA <= '0;
          syncB <= '0;
        end else begin
          syncA <= {syncA[SYNC_STAGES-2:0], hallA};
          syncB <= {syncB[SYNC_STAGES-2:0], hallB};
        end
      end
    end
  endgenerate

  logic hsA;
  logic hsB;
  logic complementary;
  logic restart;
  logic phaseB;
  logic forced;
  logic overTemp;

  assign hsA           = syncA[SYNC_STAGES-1];
  assign hsB           = syncB[SYNC_STAGES-1];
  assign complementary = hsA ^ hsB;
  assign restart       = complementary && (hsB != phaseB);

  // Phase tracking: only a complementary pair may move the phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseB <= 1'b0;
    end else if (restart) begin
      phaseB <= hsB;
    end
  end

  // Mode: start forced, enter on slow, decide at each change
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      forced <= 1'b1;
    end else if (restart) begin
      forced <= stat.overSlow;
    end else if (stat.overSlow) begin
      forced <= 1'b1;
    end
  end

  // Thermal mask with hysteresis
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overTemp <= 1'b0;
    end else if (tempCode >= SET_LVL) begin
      overTemp <= 1'b1;
    end else if (tempCode <= CLR_LVL) begin
      overTemp <= 1'b0;
    end
  end

  assign stb = {restart, forced, phaseB, overTemp};

  // R1
  pol_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phaseB != $past(phaseB)) |-> $past(hsA ^ hsB));

  // R7
  ot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overTemp && (tempCode > CLR_LVL)) |=> overTemp);

  // R6
  mode_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (restart && !stat.overSlow) |=> !forced);

endmodule

// File: rtl/fan_dp.sv
module fan_dp
  import fan_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int SLOW_NUM = 13,
  parameter int SLOW_DEN = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] ratedHalf,
  input  logic             selLo,
  input  logic             selHi,
  input  ctrlStb_t         stb,
  output dpStat_t          stat
);

  localparam int PW = CNT_W + FRAC_W;
  localparam int SW = CNT_W + 6;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] halfCnt;
  logic [CNT_W:0]   waitEnd;
  logic [CNT_W:0]   driveEnd;

  logic [PW-1:0]    ratedExt;
  logic [PW-1:0]    waitProd;
  logic [CNT_W-1:0] waitNext;
  logic [CNT_W-1:0] durTab [4];
  logic [1:0]       selIdx;
  logic [CNT_W:0]   endNext;

  assign ratedExt = PW'(ratedHalf);
  assign waitProd = ratedExt * PW'(WAIT_Q);
  assign waitNext = waitProd[PW-1:FRAC_W];

  // One Q10 product per selectable window width
  generate
    for (genvar i = 0; i < 4; i++) begin : g_duty
      logic [PW-1:0] durProd;
      assign durProd   = ratedExt * PW'(dutyQ(2'(i)));
      assign durTab[i] = durProd[PW-1:FRAC_W];
    end
  endgenerate

  assign selIdx  = {selHi, selLo};
  assign endNext = {1'b0, waitNext} + {1'b0, durTab[selIdx]};

  // Half-period counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfCnt <= '0;
    end else if (stb.restart) begin
      halfCnt <= '0;
    end else if (halfCnt != CNT_MAX) begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

  // Boundaries latched once per half-period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitEnd  <= '0;
      driveEnd <= '0;
    end else if (stb.restart) begin
      waitEnd  <= {1'b0, waitNext};
      driveEnd <= endNext;
    end
  end

  logic [SW-1:0] cntScaled;
  logic [SW-1:0] ratedScaled;

  assign cntScaled   = SW'(halfCnt) * SW'(SLOW_NUM);
  assign ratedScaled = SW'(ratedHalf) * SW'(SLOW_DEN);

  assign stat.overSlow = cntScaled > ratedScaled;
  assign stat.inWindow = ({1'b0, halfCnt} >= waitEnd) && ({1'b0, halfCnt} < driveEnd);

  // R8
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((halfCnt == CNT_MAX) && !stb.restart) |=> (halfCnt == CNT_MAX));

  // R9
  bound_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.restart |=> ($stable(waitEnd) && $stable(driveEnd)));

endmodule

// File: rtl/fan_duty_ctrl.sv
module fan_duty_ctrl
  import fan_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int TEMP_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TEMP_SET    = 170,
  parameter int TEMP_CLR    = 140
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hallA,
  input  logic              hallB,
  input  logic              selLo,
  input  logic              selHi,
  input  logic [TEMP_W-1:0] tempCode,
  input  logic [CNT_W-1:0]  ratedHalf,
  output logic              driveA,
  output logic              driveB,
  output logic              tachLow
);

  ctrlStb_t stb;
  dpStat_t  stat;
  logic     driveOn;

  fan_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .TEMP_W     (TEMP_W),
    .TEMP_SET   (TEMP_SET),
    .TEMP_CLR   (TEMP_CLR)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hallA   (hallA),
    .hallB   (hallB),
    .tempCode(tempCode),
    .stat    (stat),
    .stb     (stb)
  );

  fan_dp #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ratedHalf(ratedHalf),
    .selLo    (selLo),
    .selHi    (selHi),
    .stb      (stb),
    .stat     (stat)
  );

  assign driveOn = !stb.overTemp && (stb.forced || stat.inWindow);
  assign driveA  = driveOn && !stb.phaseB;
  assign driveB  = driveOn && stb.phaseB;
  assign tachLow = !stb.overTemp && stb.phaseB;

  // R2
  wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.restart && !stat.overSlow && (ratedHalf >= CNT_W'(4))) |=> (!driveA && !driveB));

  // R4
  excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(driveA && driveB));

endmodule

// File: tb/fan_duty_ctrl_bench.sv
module fan_duty_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hallA = 1'b1;
  logic        hallB = 1'b0;
  logic        selLo = 1'b0;
  logic        selHi = 1'b0;
  logic [7:0]  tempCode = 8'd25;
  logic [15:0] ratedHalf = 16'd100;
  logic        driveA;
  logic        driveB;
  logic        tachLow;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fan_duty_ctrl u_fan_duty_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hallA    (hallA),
    .hallB    (hallB),
    .selLo    (selLo),
    .selHi    (selHi),
    .tempCode (tempCode),
    .ratedHalf(ratedHalf),
    .driveA   (driveA),
    .driveB   (driveB),
    .tachLow  (tachLow)
  );

  // Behavioural reference model
  int mS1a, mS1b, mS2a, mS2b;
  int mPol, mForced, mOt, mCnt, mWait, mEnd;
  int mRestart, mSlow;

  function automatic int qOf(input int sel);
    case (sel)
      0: return 287;
      1: return 389;
      2: return 492;
      default: return 594;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1a = 0; mS1b = 0; mS2a = 0; mS2b = 0;
      mPol = 0; mForced = 1; mOt = 0; mCnt = 0; mWait = 0; mEnd = 0;
    end else begin
      mRestart = ((mS2a != mS2b) && (mS2b != mPol)) ? 1 : 0;
      mSlow = (mCnt * 13 > int'(ratedHalf) * 20) ? 1 : 0;
      if (int'(tempCode) >= 170) mOt = 1;
      else if (int'(tempCode) <= 140) mOt = 0;
      if (mRestart != 0) begin
        mForced = mSlow;
        mPol = mS2b;
        mCnt = 0;
        mWait = int'(ratedHalf) * 328 / 1024;
        mEnd = mWait + int'(ratedHalf) * qOf({selHi, selLo}) / 1024;
      end else begin
        if (mSlow != 0) mForced = 1;
        if (mCnt < 65535) mCnt = mCnt + 1;
      end
      mS2a = mS1a; mS2b = mS1b;
      mS1a = int'(hallA); mS1b = int'(hallB);
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      bit expOn, expA, expB, expT;
      string tag;
      expOn = (mOt == 0) && ((mForced != 0) || (mCnt >= mWait && mCnt < mEnd));
      expA = expOn && (mPol == 0);
      expB = expOn && (mPol != 0);
      expT = (mOt == 0) && (mPol != 0);
      tag = (mOt != 0) ? "R7" : ((mForced != 0) ? "R5" : "R3");
      compared++;
      if (driveA !== expA || driveB !== expB || tachLow !== expT) begin
        mismatched++;
        $display("FAIL %s per-cycle at %0t: got A=%b B=%b T=%b, expected A=%b B=%b T=%b",
                 tag, $time, driveA, driveB, tachLow, expA, expB, expT);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Apply a Hall pair for n cycles; count output activity at each negedge
  task automatic hold(input bit a, input bit b, input int n, input int chgAt,
                      input bit [1:0] newSel,
                      output int nAny, output int nA, output int nB,
                      output int nT, output int firstD);
    nAny = 0; nA = 0; nB = 0; nT = 0; firstD = -1;
    hallA = a;
    hallB = b;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (driveA || driveB) begin
        nAny++;
        if (firstD < 0) firstD = i;
      end
      if (driveA) nA++;
      if (driveB) nB++;
      if (tachLow) nT++;
      if (i == chgAt) {selHi, selLo} = newSel;
    end
  endtask

  initial begin
    int any, na, nb, nt, fd;
    int s1, s2, s3;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R10 reset state
    chk("R10 driveA", int'(driveA), 1);
    chk("R10 driveB", int'(driveB), 0);
    chk("R10 tachLow", int'(tachLow), 0);

    hold(1, 0, 100, 0, 2'b00, any, na, nb, nt, fd);
    hold(0, 1, 100, 0, 2'b00, any, na, nb, nt, fd);
    // R2 / R3 sel 00
    hold(1, 0, 100, 0, 2'b00, any, na, nb, nt, fd);
    chk("R3 width sel00", any, 28);
    chk("R2 first drive sample", fd, 35);
    // R3 sel 01, R4 phase B drives only driveB
    {selHi, selLo} = 2'b01;
    hold(0, 1, 100, 0, 2'b00, any, na, nb, nt, fd);
    chk("R3 width sel01", nb, 37);
    chk("R4 no driveA in phase B", na, 0);
    {selHi, selLo} = 2'b10;
    hold(1, 0, 100, 0, 2'b00, any, na, nb, nt, fd);
    chk("R3 width sel10", na, 48);
    chk("R4 no driveB in phase A", nb, 0);
    {selHi, selLo} = 2'b11;
    hold(0, 1, 100, 0, 2'b00, any, na, nb, nt, fd);
    chk("R3 width sel11", nb, 58);
    // R4 tach follows phase over a pair
    hold(1, 0, 100, 0, 2'b00, any, na, nb, nt, fd);
    s1 = nt;
    hold(0, 1, 100, 0, 2'b00, any, na, nb, nt, fd);
    chk("R4 tach over A+B pair", s1 + nt, 100);
    // R9 mid-half select change has no effect
    {selHi, selLo} = 2'b00;
    hold(1, 0, 100, 10, 2'b11, any, na, nb, nt, fd);
    chk("R9 old width kept", na, 28);
    hold(0, 1, 100, 0, 2'b11, any, na, nb, nt, fd);
    chk("R9 new width next half", nb, 58);
    // R1 non-complementary pair ignored
    hold(1, 0, 40, 0, 2'b11, any, na, nb, nt, fd);
    s1 = na; s2 = nb; s3 = nt;
    hold(1, 1, 10, 0, 2'b11, any, na, nb, nt, fd);
    s1 += na; s2 += nb; s3 += nt;
    hold(1, 0, 50, 0, 2'b11, any, na, nb, nt, fd);
    s1 += na; s2 += nb; s3 += nt;
    chk("R1 window unchanged by 11 pair", s1, 58);
    chk("R1 no driveB on 11 pair", s2, 0);
    chk("R1 tach unchanged by 11 pair", s3, 2);
    // R5 slow half-periods force full drive
    hold(0, 1, 200, 0, 2'b11, any, na, nb, nt, fd);
    hold(1, 0, 200, 0, 2'b11, any, na, nb, nt, fd);
    chk("R5 full drive when slow", any, 200);
    // R6 stays forced after slow half, leaves after fast half
    hold(0, 1, 100, 0, 2'b11, any, na, nb, nt, fd);
    chk("R6 forced after slow half", any, 100);
    hold(1, 0, 100, 0, 2'b11, any, na, nb, nt, fd);
    chk("R6 duty after fast half", na, 58);
    // R7 thermal hysteresis
    tempCode = 8'd175;
    hold(0, 1, 100, 0, 2'b11, any, na, nb, nt, fd);
    chk("R7 no drive when hot", any, 0);
    chk("R7 no tach when hot", nt, 0);
    tempCode = 8'd150;
    hold(1, 0, 100, 0, 2'b11, any, na, nb, nt, fd);
    chk("R7 held between thresholds", any, 0);
    tempCode = 8'd140;
    hold(0, 1, 100, 0, 2'b11, any, na, nb, nt, fd);
    chk("R7 cleared drive", nb, 58);
    chk("R7 cleared tach", nt, 98);
    tempCode = 8'd169;
    hold(1, 0, 100, 0, 2'b11, any, na, nb, nt, fd);
    chk("R7 below set threshold", na, 58);
    // R8 counter saturation keeps the slow verdict
    hold(0, 1, 65566, 0, 2'b11, any, na, nb, nt, fd);
    hold(1, 0, 100, 0, 2'b11, any, na, nb, nt, fd);
    chk("R8 saturated count stays forced", any, 100);
    hold(0, 1, 100, 0, 2'b11, any, na, nb, nt, fd);
    chk("R8 then back to duty", nb, 58);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule